// File: doc/BRIEF.md
# Serial Symbol Aligner with Stretched Byte Clock

This block sits behind a clock-recovery stage and runs entirely on the recovered bit clock, taking in one serial bit per cycle. It searches the bit stream for a fixed alignment pattern. Once the pattern is seen it frames every following group of `SYM_W` bits as one symbol. Each symbol is presented in parallel together with a one-cycle valid pulse and a byte-rate clock output. Downstream logic may run directly from that clock.

After power-up the block is out of alignment. It also drops alignment whenever the loss input or the invalid-symbol input is raised. While it is hunting, the byte clock stays high. When a new alignment is found, the next falling edge is delayed until the clock has met its minimum high time. As a result, a realignment never produces a short clock phase. The partly assembled symbol and any symbol not yet presented are thrown away. The alignment symbol and everything after it come out intact and in order.

Top module: `rx_byte_aligner`

## Requirements
- R1: After reset `byte_clk_o` is 1 and `sym_vld_o`, `in_sync_o` and `sym_o` are 0. No symbol is presented before the first alignment pattern has been received.
- R2: While not aligned, once the last `SYM_W` received bits equal `SYNC_PAT`, `in_sync_o` is 1 from the next cycle on. The pattern itself is the first symbol presented afterwards. The bit received first sits in the MSB of the compared window.
- R3: While aligned, every following `SYM_W` bits form one symbol, counted from the bit right after the pattern. Symbols are presented in arrival order, with the first-received bit in `sym_o[SYM_W-1]`.
- R4: A cycle with `los_i` or `sym_err_i` at 1 does the following. It makes `in_sync_o` 0 from the next cycle on. It discards the bit received in that cycle and the partly assembled symbol. It also discards every completed symbol that has not yet been presented.
- R5: Each low phase of `byte_clk_o` lasts exactly `SYM_W - SYM_W/2` cycles. Each high phase lasts at least `SYM_W/2` cycles.
- R6: `sym_vld_o` is a single-cycle pulse. It occurs exactly in the first low cycle of `byte_clk_o`, and every first low cycle carries it. `sym_o` changes only in that cycle.
- R7: While no symbol is waiting to be presented, `byte_clk_o` does not fall. Before the first alignment it therefore stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Serial data, one bit per cycle |
| los_i | input | 1 | External loss-of-alignment indication |
| sym_err_i | input | 1 | Invalid-symbol pulse from the decoder |
| sym_o | output | SYM_W | Parallel symbol, first bit in MSB |
| sym_vld_o | output | 1 | Symbol presented this cycle |
| byte_clk_o | output | 1 | Byte-rate clock, falls with each new symbol |
| in_sync_o | output | 1 | Alignment held |

## Verification
The assertions check on every cycle that the exact low time and the minimum high time are respected. They also check that the valid pulse and the falling edge of the clock occur together, and that the data holds between pulses. A further check is that a loss or error input clears the alignment flag. Only the bench scenarios can show three further things. First, the symbols come out with the correct content and order after the pattern has been placed at random bit offsets behind loss events. Second, partial and unpresented symbols really are dropped. Third, the clock stays high throughout the initial search.

// File: rtl/rx_align_pkg.sv
package rx_align_pkg;
  localparam int unsigned DEF_SYM_W = 10;
  localparam logic [DEF_SYM_W-1:0] DEF_SYNC = 10'b0011111010;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } lvl_e;
endpackage

// File: rtl/rx_bit_window.sv
module rx_bit_window #(
  parameter int unsigned SYM_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             clr_i,
  output logic [SYM_W-1:0] nxt_o
);
  logic [SYM_W-1:0] win_q;

  assign nxt_o = {win_q[SYM_W-2:0], ser_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    win_q <= '0;
    else if (clr_i) win_q <= '0;
    else            win_q <= nxt_o;
  end
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl #(
  parameter int unsigned     SYM_W    = 10,
  parameter logic [SYM_W-1:0] SYNC_PAT = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] nxt_i,
  input  logic             loss_i,
  output logic             evt_o,
  output logic             in_sync_o
);
  localparam int unsigned CNT_W = $clog2(SYM_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);

  logic             in_sync_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic             match;

  assign match     = (nxt_i == SYNC_PAT);
  assign evt_o     = !loss_i && (in_sync_q ? (bit_cnt_q == LAST) : match);
  assign in_sync_o = in_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_sync_q <= 1'b0;
      bit_cnt_q <= '0;
    end else if (loss_i) begin
      in_sync_q <= 1'b0;
      bit_cnt_q <= '0;
    end else if (!in_sync_q) begin
      if (match) begin
        in_sync_q <= 1'b1;
        bit_cnt_q <= '0;
      end
    end else begin
      bit_cnt_q <= evt_o ? '0 : bit_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rx_clk_stretch.sv
module rx_clk_stretch
  import rx_align_pkg::*;
#(
  parameter int unsigned SYM_W = 10,
  parameter int unsigned HI_W  = 5,
  parameter int unsigned LO_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             flush_i,
  output logic             bclk_o,
  output logic [SYM_W-1:0] sym_o,
  output logic             vld_o
);
  localparam int unsigned RUN_W = $clog2(SYM_W + 1);
  localparam logic [RUN_W-1:0] HI_N = RUN_W'(HI_W);
  localparam logic [RUN_W-1:0] LO_N = RUN_W'(LO_W);

  lvl_e             lvl_q;
  logic [RUN_W-1:0] run_q;
  logic [SYM_W-1:0] pend_q, sym_q;
  logic             pend_v_q, vld_q;
  logic             fire;

  // fall only once the high phase is long enough and a symbol waits
  assign fire = (lvl_q == LVL_HIGH) && (run_q >= HI_N) && pend_v_q && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= LVL_HIGH;
      run_q <= '0;
    end else if (lvl_q == LVL_LOW) begin
      if (run_q == LO_N) begin
        lvl_q <= LVL_HIGH;
        run_q <= RUN_W'(1);
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else if (fire) begin
      lvl_q <= LVL_LOW;
      run_q <= RUN_W'(1);
    end else if (run_q < HI_N) begin
      run_q <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (flush_i) begin
      pend_v_q <= 1'b0;
    end else if (evt_i) begin
      pend_q   <= sym_i;
      pend_v_q <= 1'b1;
    end else if (fire) begin
      pend_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= fire;
      if (fire) sym_q <= pend_q;
    end
  end

  assign bclk_o = (lvl_q == LVL_HIGH);
  assign sym_o  = sym_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/rx_byte_aligner.sv
module rx_byte_aligner
  import rx_align_pkg::*;
#(
  parameter int unsigned      SYM_W    = DEF_SYM_W,
  parameter logic [SYM_W-1:0] SYNC_PAT = DEF_SYNC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             los_i,
  input  logic             sym_err_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             sym_vld_o,
  output logic             byte_clk_o,
  output logic             in_sync_o
);
  localparam int unsigned HI_W = SYM_W / 2;
  localparam int unsigned LO_W = SYM_W - HI_W;

  logic             loss;
  logic [SYM_W-1:0] nxt;
  logic             evt;

  assign loss = los_i | sym_err_i;

  rx_bit_window #(.SYM_W(SYM_W)) i_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ser_i  (ser_i),
    .clr_i  (loss),
    .nxt_o  (nxt)
  );

  rx_frame_ctrl #(.SYM_W(SYM_W), .SYNC_PAT(SYNC_PAT)) i_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nxt_i     (nxt),
    .loss_i    (loss),
    .evt_o     (evt),
    .in_sync_o (in_sync_o)
  );

  rx_clk_stretch #(.SYM_W(SYM_W), .HI_W(HI_W), .LO_W(LO_W)) i_stretch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .sym_i   (nxt),
    .flush_i (loss),
    .bclk_o  (byte_clk_o),
    .sym_o   (sym_o),
    .vld_o   (sym_vld_o)
  );
endmodule

// File: rtl/rx_byte_aligner_chk.sv
module rx_byte_aligner_chk #(
  parameter int unsigned SYM_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             los_i,
  input logic             sym_err_i,
  input logic [SYM_W-1:0] sym_o,
  input logic             sym_vld_o,
  input logic             byte_clk_o,
  input logic             in_sync_o
);
  localparam int unsigned HI_W = SYM_W / 2;
  localparam int unsigned LO_W = SYM_W - HI_W;

  logic        prev_q;
  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      run_q  <= '0;
    end else begin
      prev_q <= byte_clk_o;
      if (byte_clk_o != prev_q) run_q <= 16'd1;
      else if (run_q != 16'hffff) run_q <= run_q + 16'd1;
    end
  end

  AST_LOW_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_clk_o && !prev_q) |-> (run_q == 16'(LO_W)));  // R5
  AST_HIGH_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_clk_o && prev_q) |-> (run_q >= 16'(HI_W)));  // R5
  AST_VLD_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |-> $fell(byte_clk_o));  // R6
  AST_FALL_HAS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(byte_clk_o) |-> sym_vld_o);  // R6
  AST_VLD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |=> !sym_vld_o);  // R6
  AST_SYM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_vld_o |-> $stable(sym_o));  // R6
  AST_LOSS_UNSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (los_i || sym_err_i) |=> !in_sync_o);  // R4
endmodule

bind rx_byte_aligner rx_byte_aligner_chk #(.SYM_W(SYM_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .los_i      (los_i),
  .sym_err_i  (sym_err_i),
  .sym_o      (sym_o),
  .sym_vld_o  (sym_vld_o),
  .byte_clk_o (byte_clk_o),
  .in_sync_o  (in_sync_o)
);

// File: tb/test_rx_byte_aligner.sv
`timescale 1ns/1ps
module test_rx_byte_aligner;
  localparam int unsigned W    = 10;
  localparam int unsigned HI_W = W / 2;
  localparam int unsigned LO_W = W - HI_W;
  localparam logic [W-1:0] SYNC = 10'b0011111010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser = 1'b0, los = 1'b0, err = 1'b0;
  logic [W-1:0] sym;
  logic vld, bclk, in_sync;

  always #2.5 clk = ~clk;

  rx_byte_aligner #(.SYM_W(W), .SYNC_PAT(SYNC)) i_rx_byte_aligner (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .los_i(los), .sym_err_i(err),
    .sym_o(sym), .sym_vld_o(vld), .byte_clk_o(bclk), .in_sync_o(in_sync)
  );

  int errs = 0, checks = 0;
  logic [W-1:0] expq[$];
  bit   first_is_sync = 0;
  bit   hunting_first = 1;
  bit   exp_sync = 0, last_loss = 0;
  logic prev_bclk = 1'b1;
  int   run = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd_sym();
    return W'($urandom);
  endfunction

  // sample outputs of the last edge
  task automatic monitor();
    logic [W-1:0] e;
    if (bclk !== prev_bclk) begin
      if (prev_bclk) check(run >= int'(HI_W), "R5 high width", run, HI_W);
      else           check(run == int'(LO_W), "R5 low width", run, LO_W);
      run = 1;
    end else run++;
    if (vld) begin
      check(bclk == 1'b0 && prev_bclk == 1'b1, "R6 vld with fall", {bclk, prev_bclk}, 2'b01);
      if (expq.size() == 0) check(0, "R4 unexpected symbol", sym, 0);
      else begin
        e = expq.pop_front();
        if (first_is_sync) check(sym == e, "R2 sync first", sym, e);
        else               check(sym == e, "R3 symbol order", sym, e);
        first_is_sync = 0;
      end
    end
    if (hunting_first) begin
      check(bclk == 1'b1, "R7 clock held high", bclk, 1);
      check(vld == 1'b0, "R1 no early symbol", vld, 0);
    end
    if (last_loss) check(in_sync == exp_sync, "R4 sync dropped", in_sync, exp_sync);
    else           check(in_sync == exp_sync, "R2 sync flag", in_sync, exp_sync);
    prev_bclk = bclk;
  endtask

  task automatic cycle(input logic b, input logic l, input logic r, input bit sync_end);
    @(negedge clk);
    monitor();
    ser = b; los = l; err = r;
    last_loss = l | r;
    if (l | r) exp_sync = 0;
    else if (sync_end) exp_sync = 1;
  endtask

  task automatic send_sym(input logic [W-1:0] s, input bit is_sync);
    for (int i = 0; i < int'(W); i++) cycle(s[W-1-i], 1'b0, 1'b0, is_sync && i == int'(W) - 1);
    if (is_sync && expq.size() == 0) first_is_sync = 1;
    expq.push_back(s);
  endtask

  task automatic garbage(input int n);
    for (int i = 0; i < n; i++) cycle(logic'(i % 2), 1'b0, 1'b0, 1'b0);
  endtask

  task automatic lose(input bit use_err, input int partial);
    for (int i = 0; i < partial; i++) cycle(logic'($urandom % 2), 1'b0, 1'b0, 1'b0);
    cycle(logic'($urandom % 2), !use_err, use_err, 1'b0);
    expq.delete();  // R4 pending and partial symbols are dropped
    first_is_sync = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0019));
    repeat (3) @(negedge clk);
    check(bclk == 1'b1 && vld == 1'b0 && in_sync == 1'b0 && sym == '0, "R1 reset state",
          {bclk, vld, in_sync, sym}, {3'b100, {W{1'b0}}});
    rst_n = 1'b1;
    garbage(7);
    send_sym(SYNC, 1);
    hunting_first = 0;
    for (int i = 0; i < 15; i++) send_sym(rnd_sym(), 0);
    for (int k = 0; k < 10; k++) begin
      int p, g, n;
      p = (k == 0) ? 0 : (k == 1) ? int'(W) - 1 : int'($urandom % W);
      g = (k == 0) ? 0 : (k == 2) ? 1 : int'($urandom % (3 * W));
      n = 4 + int'($urandom % 10);
      lose(k[0], p);
      garbage(g);
      send_sym(SYNC, 1);
      for (int i = 0; i < n; i++) send_sym(rnd_sym(), 0);
    end
    send_sym(rnd_sym(), 0);
    for (int i = 0; i < int'(W) - 1; i++) cycle(1'b0, 1'b0, 1'b0, 1'b0);
    check(expq.size() <= 1, "R3 symbols delivered", expq.size(), 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule